// File: doc/BRIEF.md
# Prioritized Interrupt Exception Entry Unit

This unit sits beside a processor's exception logic. Each cycle it looks at the raised interrupt lines, the enable lines and a per-level routing mask, and finds the highest priority level that has an interrupt both raised and enabled. If that level is strictly above the interrupt level held in the current processor status word, the unit takes the interrupt. On the next clock edge it commits every state change that entry needs, in one step.

An interrupt above level 1 goes straight to its own vector. The return address and the old status word are saved in a save-register pair that belongs to that level, and the status word gets the new level and the exception-mode flag. A level-1 interrupt becomes a general exception instead. The exception cause register is written, and the user, kernel or double-exception vector is chosen from the mode bits of the status word. A double exception keeps its return address in a separate save register when the build has one. Vector targets can be moved at run time by a base-address input.

The core supplies the current PC and status word and loads `nextPc` and `nextPs` when it sees the `taken` pulse. Status-word layout: interrupt level in bits [3:0], exception mode in bit 4, user mode in bit 5.

Top module: `irqEntryUnit`

## Requirements
- R1: An interrupt is taken only when the pending level is strictly greater than `curPs[3:0]`. A level counts as pending only if the AND of its `levelMask` row with `irqSet` and `irqEnable` is nonzero. Levels exist only from 1 to NUM_LEVELS (`levelMask` row k belongs to level k+1), so a status level of NUM_LEVELS or more blocks all interrupts.
- R2: When several levels are pending, the highest numbered one is the one considered, and `takenLevel` reports it.
- R3: On taking level L>1, `epcSave[L-1]` receives the PC and `epsSave[L-1]` receives the status word as they stood on the input cycle.
- R4: On taking level L>1, `nextPs` equals the old status word with bits [3:0] replaced by L and bit 4 set. `nextPc` is the configured vector HIGH_OFF + (L-2)*HIGH_STRIDE (relocated per R9). `takenKind` is 4.
- R5: On taking level 1, `excCause` becomes LEVEL1_CAUSE (default 4). A level above 1 leaves `excCause` unchanged.
- R6: On taking level 1 with status bit 4 set, `takenKind` is 3 (double) and `nextPc` is the DOUBLE_OFF vector. The PC goes to `depcSave` when HAS_DEPC=1; otherwise it goes to `epcSave[0]`, and `depcSave` stays 0.
- R7: On taking level 1 with status bit 4 clear, the PC goes to `epcSave[0]`. If status bit 5 is set, `takenKind` is 2 with the USER_OFF vector; otherwise it is 1 with the KERNEL_OFF vector.
- R8: Level-1 entry sets status bit 4 in `nextPs` and keeps every other bit of the status word.
- R9: When RELOCATABLE=1, the vector target is the configured vector (DEF_VECBASE + offset) minus DEF_VECBASE plus `vecBase`. When RELOCATABLE=0, `vecBase` has no effect.
- R10: `taken` is high for exactly the one cycle after an input cycle that meets R1, and all outputs for that entry change on that same edge. Without a take, no output register other than `taken` changes.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSet | input | NUM_IRQ | Raised interrupt lines |
| irqEnable | input | NUM_IRQ | Interrupt enable lines |
| levelMask | input | NUM_LEVELS x NUM_IRQ | Row k selects the lines routed to level k+1 |
| curPs | input | 32 | Current processor status word |
| curPc | input | 32 | Current program counter |
| vecBase | input | 32 | Run-time vector base |
| taken | output | 1 | One-cycle entry pulse |
| takenLevel | output | 4 | Level of the last entry |
| takenKind | output | 3 | Kind of last entry: 1 kernel, 2 user, 3 double, 4 high level |
| nextPc | output | 32 | Vector target of the last entry |
| nextPs | output | 32 | Status word after the last entry |
| epcSave | output | NUM_LEVELS x 32 | Return-address save registers, index k for level k+1 |
| epsSave | output | (NUM_LEVELS-1) x 32 | Status save registers, index k for level k+1 (k from 1) |
| depcSave | output | 32 | Double-exception return address |
| excCause | output | 32 | Exception cause |

## Verification
The hardest case to reach from the ports is the double exception. It needs a level-1 line raised and enabled, a status word with the exception-mode bit set, and a status level of 0. Random status words rarely line up that way, and the result must differ between a build with the separate save register and a build without one. The bench therefore runs two instances with different configurations side by side and drives this case directly. It also runs a long stretch in which the status word follows the unit's own `nextPs`, as a real core's would. That loop reaches the nesting pattern where a high-level entry masks lower levels until the status word is lowered again.

// File: rtl/irqEntryPkg.sv
package irqEntryPkg;
  localparam int PsLvlW   = 4;
  localparam int PsExcmBit = 4;
  localparam int PsUmBit   = 5;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_KERNEL = 3'd1,
    KIND_USER   = 3'd2,
    KIND_DOUBLE = 3'd3,
    KIND_HIGH   = 3'd4
  } entryKindT;

  // control -> datapath strobes
  typedef struct packed {
    logic              take;
    entryKindT         kind;
    logic [PsLvlW-1:0] level;
  } entryStrobeT;
endpackage

// File: rtl/irqLevelEncoder.sv
module irqLevelEncoder #(
  parameter int NUM_LEVELS = 5,
  parameter int NUM_IRQ    = 16
) (
  input  logic [NUM_IRQ-1:0]                 irqSet,
  input  logic [NUM_IRQ-1:0]                 irqEnable,
  input  logic [NUM_LEVELS-1:0][NUM_IRQ-1:0] levelMask,
  output logic [3:0]                         pendLevel,
  output logic                               pendValid
);
  logic [NUM_LEVELS-1:0] lvlHit;
  logic [NUM_IRQ-1:0]    liveIrq;

  assign liveIrq = irqSet & irqEnable;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gHit
    assign lvlHit[g] = |(levelMask[g] & liveIrq);
  end

  // ascending scan: the last hit (highest level) wins
  always_comb begin
    pendLevel = '0;
    pendValid = 1'b0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (lvlHit[l]) begin
        pendLevel = 4'(l + 1);
        pendValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqEntryCtrl.sv
module irqEntryCtrl
  import irqEntryPkg::*;
(
  input  logic [3:0]  pendLevel,
  input  logic        pendValid,
  input  logic [3:0]  psLvl,
  input  logic        psExcm,
  input  logic        psUm,
  output entryStrobeT strobe
);
  logic takeNow;

  assign takeNow = pendValid && (pendLevel > psLvl);

  always_comb begin
    strobe.take  = takeNow;
    strobe.level = pendLevel;
    strobe.kind  = KIND_NONE;
    if (takeNow) begin
      if (pendLevel > 4'd1)  strobe.kind = KIND_HIGH;
      else if (psExcm)       strobe.kind = KIND_DOUBLE;
      else if (psUm)         strobe.kind = KIND_USER;
      else                   strobe.kind = KIND_KERNEL;
    end
  end
endmodule

// File: rtl/irqEntryDatapath.sv
module irqEntryDatapath
  import irqEntryPkg::*;
#(
  parameter int          NUM_LEVELS   = 5,
  parameter bit          HAS_DEPC     = 1'b1,
  parameter bit          RELOCATABLE  = 1'b1,
  parameter logic [31:0] DEF_VECBASE  = 32'h4000_0000,
  parameter logic [31:0] KERNEL_OFF   = 32'h0000_0300,
  parameter logic [31:0] USER_OFF     = 32'h0000_0340,
  parameter logic [31:0] DOUBLE_OFF   = 32'h0000_03C0,
  parameter logic [31:0] HIGH_OFF     = 32'h0000_0180,
  parameter logic [31:0] HIGH_STRIDE  = 32'h0000_0040,
  parameter logic [31:0] LEVEL1_CAUSE = 32'd4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  entryStrobeT                 strobe,
  input  logic [31:0]                 curPc,
  input  logic [31:0]                 curPs,
  input  logic [31:0]                 vecBase,
  output logic                        takenQ,
  output logic [3:0]                  levelQ,
  output entryKindT                   kindQ,
  output logic [31:0]                 pcQ,
  output logic [31:0]                 psQ,
  output logic [NUM_LEVELS-1:0][31:0] epcQ,
  output logic [NUM_LEVELS-1:1][31:0] epsQ,
  output logic [31:0]                 depcQ,
  output logic [31:0]                 causeQ
);
  logic [31:0] vecOff;
  logic [31:0] cfgVec;
  logic [31:0] target;
  logic [31:0] psNext;
  logic        dblToEpc1;

  always_comb begin
    unique case (strobe.kind)
      KIND_USER:   vecOff = USER_OFF;
      KIND_DOUBLE: vecOff = DOUBLE_OFF;
      KIND_HIGH:   vecOff = HIGH_OFF + 32'(strobe.level - 4'd2) * HIGH_STRIDE;
      default:     vecOff = KERNEL_OFF;
    endcase
  end

  assign cfgVec = DEF_VECBASE + vecOff;

  if (RELOCATABLE) begin : gReloc
    assign target = cfgVec - DEF_VECBASE + vecBase;
  end else begin : gFixed
    assign target = cfgVec;
  end

  always_comb begin
    psNext = curPs;
    psNext[PsExcmBit] = 1'b1;
    if (strobe.kind == KIND_HIGH) psNext[PsLvlW-1:0] = strobe.level;
  end

  assign dblToEpc1 = (strobe.kind == KIND_DOUBLE) && !HAS_DEPC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenQ <= 1'b0;
      levelQ <= '0;
      kindQ  <= KIND_NONE;
      pcQ    <= '0;
      psQ    <= '0;
      epcQ   <= '0;
      epsQ   <= '0;
      causeQ <= '0;
    end else begin
      takenQ <= strobe.take;
      if (strobe.take) begin
        levelQ <= strobe.level;
        kindQ  <= strobe.kind;
        pcQ    <= target;
        psQ    <= psNext;
        if (strobe.kind != KIND_HIGH) causeQ <= LEVEL1_CAUSE;
        if (strobe.kind == KIND_KERNEL || strobe.kind == KIND_USER || dblToEpc1)
          epcQ[0] <= curPc;
        for (int l = 2; l <= NUM_LEVELS; l++) begin
          if (strobe.kind == KIND_HIGH && strobe.level == 4'(l)) begin
            epcQ[l-1] <= curPc;
            epsQ[l-1] <= curPs;
          end
        end
      end
    end
  end

  if (HAS_DEPC) begin : gDepc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) depcQ <= '0;
      else if (strobe.take && strobe.kind == KIND_DOUBLE) depcQ <= curPc;
    end
  end else begin : gNoDepc
    assign depcQ = '0;
  end
endmodule

// File: rtl/irqEntryUnit.sv
module irqEntryUnit
  import irqEntryPkg::*;
#(
  parameter int          NUM_LEVELS   = 5,
  parameter int          NUM_IRQ      = 16,
  parameter bit          HAS_DEPC     = 1'b1,
  parameter bit          RELOCATABLE  = 1'b1,
  parameter logic [31:0] DEF_VECBASE  = 32'h4000_0000,
  parameter logic [31:0] KERNEL_OFF   = 32'h0000_0300,
  parameter logic [31:0] USER_OFF     = 32'h0000_0340,
  parameter logic [31:0] DOUBLE_OFF   = 32'h0000_03C0,
  parameter logic [31:0] HIGH_OFF     = 32'h0000_0180,
  parameter logic [31:0] HIGH_STRIDE  = 32'h0000_0040,
  parameter logic [31:0] LEVEL1_CAUSE = 32'd4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_IRQ-1:0]                 irqSet,
  input  logic [NUM_IRQ-1:0]                 irqEnable,
  input  logic [NUM_LEVELS-1:0][NUM_IRQ-1:0] levelMask,
  input  logic [31:0]                        curPs,
  input  logic [31:0]                        curPc,
  input  logic [31:0]                        vecBase,
  output logic                               taken,
  output logic [3:0]                         takenLevel,
  output logic [2:0]                         takenKind,
  output logic [31:0]                        nextPc,
  output logic [31:0]                        nextPs,
  output logic [NUM_LEVELS-1:0][31:0]        epcSave,
  output logic [NUM_LEVELS-1:1][31:0]        epsSave,
  output logic [31:0]                        depcSave,
  output logic [31:0]                        excCause
);
  // NUM_LEVELS must lie in 2..15 to fit the 4-bit status level field
  logic [3:0]  pendLevel;
  logic        pendValid;
  entryStrobeT strobe;
  entryKindT   kindQ;

  irqLevelEncoder #(.NUM_LEVELS(NUM_LEVELS), .NUM_IRQ(NUM_IRQ)) enc_i (
    .irqSet    (irqSet),
    .irqEnable (irqEnable),
    .levelMask (levelMask),
    .pendLevel (pendLevel),
    .pendValid (pendValid)
  );

  irqEntryCtrl ctrl_i (
    .pendLevel (pendLevel),
    .pendValid (pendValid),
    .psLvl     (curPs[PsLvlW-1:0]),
    .psExcm    (curPs[PsExcmBit]),
    .psUm      (curPs[PsUmBit]),
    .strobe    (strobe)
  );

  irqEntryDatapath #(
    .NUM_LEVELS   (NUM_LEVELS),
    .HAS_DEPC     (HAS_DEPC),
    .RELOCATABLE  (RELOCATABLE),
    .DEF_VECBASE  (DEF_VECBASE),
    .KERNEL_OFF   (KERNEL_OFF),
    .USER_OFF     (USER_OFF),
    .DOUBLE_OFF   (DOUBLE_OFF),
    .HIGH_OFF     (HIGH_OFF),
    .HIGH_STRIDE  (HIGH_STRIDE),
    .LEVEL1_CAUSE (LEVEL1_CAUSE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .curPc   (curPc),
    .curPs   (curPs),
    .vecBase (vecBase),
    .takenQ  (taken),
    .levelQ  (takenLevel),
    .kindQ   (kindQ),
    .pcQ     (nextPc),
    .psQ     (nextPs),
    .epcQ    (epcSave),
    .epsQ    (epsSave),
    .depcQ   (depcSave),
    .causeQ  (excCause)
  );

  assign takenKind = kindQ;
endmodule

// File: rtl/irqEntryChecker.sv
module irqEntryChecker #(
  parameter int          NUM_LEVELS   = 5,
  parameter logic [31:0] LEVEL1_CAUSE = 32'd4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [31:0]                 curPs,
  input logic [31:0]                 curPc,
  input logic                        taken,
  input logic [3:0]                  takenLevel,
  input logic [31:0]                 nextPc,
  input logic [31:0]                 nextPs,
  input logic [NUM_LEVELS-1:0][31:0] epcSave,
  input logic [NUM_LEVELS-1:1][31:0] epsSave,
  input logic [31:0]                 excCause
);
  p_level_above_cur_r1: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (takenLevel > $past(curPs[3:0])));

  p_level_in_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (takenLevel >= 4'd1 && takenLevel <= 4'(NUM_LEVELS)));

  p_high_ps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (taken && takenLevel > 4'd1) |-> (nextPs[3:0] == takenLevel && nextPs[4]));

  p_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (taken && takenLevel == 4'd1) |-> (excCause == LEVEL1_CAUSE));

  p_excm_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (taken && takenLevel == 4'd1) |-> (nextPs == ($past(curPs) | 32'h10)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !taken |-> ($stable(nextPc) && $stable(nextPs) && $stable(excCause)));

  for (genvar l = 2; l <= NUM_LEVELS; l++) begin : gSave
    p_save_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
      (taken && takenLevel == 4'(l)) |->
        (epcSave[l-1] == $past(curPc) && epsSave[l-1] == $past(curPs)));
  end
endmodule

bind irqEntryUnit irqEntryChecker #(
  .NUM_LEVELS   (NUM_LEVELS),
  .LEVEL1_CAUSE (LEVEL1_CAUSE)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .curPs      (curPs),
  .curPc      (curPc),
  .taken      (taken),
  .takenLevel (takenLevel),
  .nextPc     (nextPc),
  .nextPs     (nextPs),
  .epcSave    (epcSave),
  .epsSave    (epsSave),
  .excCause   (excCause)
);

// File: tb/irqEntryUnit_tb_top.sv
module irqEntryUnit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;
  localparam int NI = 16;
  localparam logic [31:0] DEFB = 32'h4000_0000;
  localparam logic [31:0] KOFF = 32'h300, UOFF = 32'h340, DOFF = 32'h3C0;
  localparam logic [31:0] HOFF = 32'h180, HSTR = 32'h40, CAUSE1 = 32'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NI-1:0] irqSet = '0, irqEnable = '0;
  logic [NL-1:0][NI-1:0] levelMask;
  logic [31:0] curPs = '0, curPc = '0, vecBase = '0;

  logic              oTaken [2];
  logic [3:0]        oLevel [2];
  logic [2:0]        oKind  [2];
  logic [31:0]       oPc [2], oPs [2], oDepc [2], oCause [2];
  logic [NL-1:0][31:0] oEpc [2];
  logic [NL-1:1][31:0] oEps [2];

  irqEntryUnit #(.NUM_LEVELS(NL), .NUM_IRQ(NI), .HAS_DEPC(1'b1), .RELOCATABLE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqEnable(irqEnable), .levelMask(levelMask),
    .curPs(curPs), .curPc(curPc), .vecBase(vecBase),
    .taken(oTaken[0]), .takenLevel(oLevel[0]), .takenKind(oKind[0]), .nextPc(oPc[0]),
    .nextPs(oPs[0]), .epcSave(oEpc[0]), .epsSave(oEps[0]), .depcSave(oDepc[0]),
    .excCause(oCause[0]));

  irqEntryUnit #(.NUM_LEVELS(NL), .NUM_IRQ(NI), .HAS_DEPC(1'b0), .RELOCATABLE(1'b0)) dutAlt_i (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqEnable(irqEnable), .levelMask(levelMask),
    .curPs(curPs), .curPc(curPc), .vecBase(vecBase),
    .taken(oTaken[1]), .takenLevel(oLevel[1]), .takenKind(oKind[1]), .nextPc(oPc[1]),
    .nextPs(oPs[1]), .epcSave(oEpc[1]), .epsSave(oEps[1]), .depcSave(oDepc[1]),
    .excCause(oCause[1]));

  // reference model state, index 0 = relocatable with DEPC, 1 = fixed without
  logic [31:0] mEpc [2][NL];
  logic [31:0] mEps [2][NL];
  logic [31:0] mPc [2], mPs [2], mDepc [2], mCause [2];
  logic [3:0]  mLvl [2];
  logic [2:0]  mKind [2];
  logic        mTaken [2];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit wasReset = 1;

  task automatic chk(string req, int c, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s inst%0d %s actual=%h expected=%h t=%0t", req, c, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    for (int c = 0; c < 2; c++) begin
      string rq;
      rq = wasReset ? "R11" : "R10";
      chk(rq, c, "taken", 32'(oTaken[c]), 32'(mTaken[c]));
      chk(wasReset ? "R11" : "R2", c, "takenLevel", 32'(oLevel[c]), 32'(mLvl[c]));
      chk(wasReset ? "R11" : "R7", c, "takenKind", 32'(oKind[c]), 32'(mKind[c]));
      chk(wasReset ? "R11" : "R9", c, "nextPc", oPc[c], mPc[c]);
      chk(wasReset ? "R11" : "R8", c, "nextPs", oPs[c], mPs[c]);
      chk(wasReset ? "R11" : "R6", c, "depcSave", oDepc[c], mDepc[c]);
      chk(wasReset ? "R11" : "R5", c, "excCause", oCause[c], mCause[c]);
      for (int l = 0; l < NL; l++) begin
        chk(wasReset ? "R11" : "R3", c, $sformatf("epcSave[%0d]", l), oEpc[c][l], mEpc[c][l]);
        if (l > 0)
          chk(wasReset ? "R11" : "R3", c, $sformatf("epsSave[%0d]", l), oEps[c][l], mEps[c][l]);
      end
    end
    vectors++;
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mPc[c] = 0; mPs[c] = 0; mDepc[c] = 0; mCause[c] = 0;
      mLvl[c] = 0; mKind[c] = 0; mTaken[c] = 0;
      for (int l = 0; l < NL; l++) begin mEpc[c][l] = 0; mEps[c][l] = 0; end
    end
  endtask

  task automatic modelEdge();
    int pl;
    logic [31:0] off;
    pl = 0;
    for (int l = NL; l >= 1; l--)
      if (pl == 0 && ((levelMask[l-1] & irqSet & irqEnable) != 0)) pl = l;
    for (int c = 0; c < 2; c++) begin
      if (pl != 0 && pl > int'(curPs[3:0])) begin
        mTaken[c] = 1;
        mLvl[c] = 4'(pl);
        if (pl > 1) begin
          mKind[c] = 3'd4;
          mEpc[c][pl-1] = curPc;
          mEps[c][pl-1] = curPs;
          mPs[c] = {curPs[31:5], 1'b1, 4'(pl)};
          off = HOFF + HSTR * 32'(pl - 2);
        end else begin
          mCause[c] = CAUSE1;
          mPs[c] = curPs | 32'h10;
          if (curPs[4]) begin
            mKind[c] = 3'd3;
            off = DOFF;
            if (c == 0) mDepc[c] = curPc; else mEpc[c][0] = curPc;
          end else begin
            mEpc[c][0] = curPc;
            mKind[c] = curPs[5] ? 3'd2 : 3'd1;
            off = curPs[5] ? UOFF : KOFF;
          end
        end
        mPc[c] = (c == 0) ? vecBase + off : DEFB + off;
      end else begin
        mTaken[c] = 0;
      end
    end
  endtask

  // one clock: check outputs, drive the next inputs, predict the next edge
  task automatic step(logic r, logic [NI-1:0] s, logic [NI-1:0] e,
                      logic [31:0] ps, logic [31:0] pc, logic [31:0] vb);
    @(negedge clk);
    compareAll();
    rstN = r; irqSet = s; irqEnable = e; curPs = ps; curPc = pc; vecBase = vb;
    wasReset = !r;
    if (!r) modelReset(); else modelEdge();
  endtask

  initial begin
    // line i routed to level (i % NL) + 1: level1 = bits 0,5,10,15
    for (int k = 0; k < NL; k++)
      for (int i = 0; i < NI; i++) levelMask[k][i] = ((i % NL) == k);
  end

  initial begin
    logic [31:0] psFb;
    modelReset();
    // R11: reset holds outputs at zero even with interrupts live
    repeat (3) step(1'b0, '1, '1, 32'h0, 32'h1111_0000, 32'h8000_0000);
    // R10: idle, nothing taken
    repeat (2) step(1'b1, '0, '1, 32'h0, 32'h1000_0000, 32'h8000_0000);
    // R7: kernel entry (bit0 -> level1), then user entry
    step(1'b1, 16'h0001, '1, 32'h0000_0000, 32'h1000_0100, 32'h8000_0000);
    step(1'b1, '0, '1, 32'h0, 32'h0, 32'h8000_0000);
    step(1'b1, 16'h0020, '1, 32'h0000_0020, 32'h1000_0200, 32'h8000_0000);
    step(1'b1, '0, '1, 32'h0, 32'h0, 32'h8000_0000);
    // R6: double exception, level 0 with exception mode set
    step(1'b1, 16'h0400, '1, 32'hA5A5_0010, 32'h1000_0300, 32'h8000_0000);
    step(1'b1, '0, '1, 32'h0, 32'h0, 32'h8000_0000);
    // R1: level1 blocked at status level 1; disabled line ignored
    step(1'b1, 16'h0001, '1, 32'h0000_0001, 32'h1000_0400, 32'h8000_0000);
    step(1'b1, 16'h0004, 16'hFFFB, 32'h0, 32'h1000_0500, 32'h8000_0000);
    // R1: level3 equal to status level blocked, strictly above taken
    step(1'b1, 16'h0004, '1, 32'h0000_0003, 32'h1000_0600, 32'h8000_0000);
    step(1'b1, 16'h0004, '1, 32'h0000_0002, 32'h1000_0700, 32'h8000_0000);
    // R1: status level 15 above every configured level
    step(1'b1, '1, '1, 32'h0000_000F, 32'h1000_0800, 32'h8000_0000);
    // R2 R3 R4: levels 2 and 4 pending, 4 wins
    step(1'b1, 16'h000A, '1, 32'hC0DE_0020, 32'h1000_0900, 32'h8000_0000);
    // R9: new vector base, top level 5
    step(1'b1, 16'h0010, '1, 32'h0000_0000, 32'h1000_0A00, 32'h2200_0000);
    step(1'b1, '0, '1, 32'h0, 32'h0, 32'h2200_0000);
    // R5: high level leaves cause; level1 rewrites it
    step(1'b1, 16'h0002, '1, 32'h0, 32'h1000_0B00, 32'h2200_0000);
    // R11: reset mid-run clears everything
    step(1'b0, '0, '0, 32'h0, 32'h0, 32'h0);
    step(1'b1, '0, '0, 32'h0, 32'h0, 32'h0);
    // closed loop: status follows the unit's own output, as a core would
    psFb = 32'h0;
    for (int n = 0; n < 3000; n++) begin
      logic [NI-1:0] s;
      s = 16'($urandom) & 16'($urandom);
      if (n % 9 == 0) psFb = $urandom & 32'hFFFF_FF30;
      step(1'b1, s, 16'($urandom) | 16'h8421, psFb, $urandom, (n % 50 < 25) ? 32'h6000_0000 : 32'h0);
      if (mTaken[0]) psFb = mPs[0];
    end
    step(1'b1, '0, '0, 32'h0, 32'h0, 32'h0);
    step(1'b1, '0, '0, 32'h0, 32'h0, 32'h0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule